// File: doc/BRIEF.md
# Write-Only I2C Setpoint Target

This block is a receive-only I2C target that holds the output setpoint code of a regulator, together with a flag that picks the source of the regulation target. After power-up, and after every re-enable, the flag selects the external start-up setting. A bus master addresses the block, writes one or more code bytes, and finishes with STOP. That STOP moves the last written code into the active register and hands control to the internal DAC code. The DAC keeps control until `enable` is pulled low.

The block samples SCL and SDA with the system clock through two-flop synchronizers. It requires the system clock to run at least eight times faster than SCL. It never drives SCL. It drives SDA only by pulling it low during an acknowledge slot, through `sdaPullLow`, which feeds an external open-drain pad. Incoming bits are shifted in MSB first on SCL rising edges. START is detected when SDA falls while SCL is high, and STOP when SDA rises while SCL is high.

Top module: `setpoint_i2c_target`

## Requirements
- R1: After reset `dacCode` is 0, `dacSel` is 0 (external start-up selected) and `sdaPullLow` is 0.
- R2: The block acknowledges the first byte after START when its upper seven bits equal `DEV_ADDR` and bit 0 (the direction bit) is 0. It does this by holding `sdaPullLow` high from the SCL falling edge after the eighth bit until the SCL falling edge that ends the ninth bit.
- R3: If the address bits differ from `DEV_ADDR`, the address byte is not acknowledged. Every following byte up to the next START is then neither acknowledged nor stored.
- R4: A matching address with direction bit 1 (a read) is not acknowledged, and the rest of that transfer is ignored in the same way as in R3.
- R5: Each data byte after an acknowledged address is acknowledged. It does not change `dacCode` or `dacSel` before a STOP arrives.
- R6: A STOP that follows at least one acknowledged data byte loads the written code into `dacCode` and sets `dacSel` to 1, three system clocks after SDA rises at the pin.
- R7: When several data bytes are written in one transfer, all of them are acknowledged and only the last one is committed at STOP.
- R8: A STOP with no acknowledged data byte since the last commit leaves `dacCode` and `dacSel` unchanged.
- R9: While `enable` is 0, `dacSel` is 0 from the next clock, no byte is acknowledged and nothing is stored. After `enable` returns to 1, `dacSel` stays 0 until a new code is committed. Once `dacSel` is 1, later transfers do not clear it.
- R10: A repeated START in the middle of a transfer restarts address decoding. A code that was written but not yet committed is still committed at the next STOP.
- R11: `sdaPullLow` is never high outside an acknowledge slot, and it only asserts while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Regulator enable; low returns control to the start-up setting |
| sclIn | input | 1 | SCL level seen at the pad |
| sdaIn | input | 1 | SDA level seen at the pad |
| sdaPullLow | output | 1 | When high, the open-drain pad pulls SDA low |
| dacCode | output | 8 | Committed setpoint code |
| dacSel | output | 1 | 1: output follows `dacCode`; 0: output follows the external start-up setting |

## Verification
The assertions check three things on every cycle. First, an acknowledge drive begins only while SCL is low and ends at the next SCL fall. Second, a rejected transfer stays ignored until START or STOP. Third, the committed code and the selection flag move only on a STOP that carries pending data, and `enable` low always clears the flag. Other behaviour can only be shown by the bench's transfer scenarios, compared against a transaction-level model on every clock: which address and direction combinations earn an acknowledge, that the last of several bytes wins, and that a pending code survives a repeated START. The same applies to re-enable returning control to the start-up setting.

// File: rtl/sp_target_pkg.sv
package sp_target_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_WAITACK,
    ST_ACK,
    ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic shiftEn;
    logic loadPending;
    logic stopSeen;
  } ctlStrobe_t;
endpackage

// File: rtl/sp_bus_ctl.sv
module sp_bus_ctl
  import sp_target_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2C,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  output ctlStrobe_t        strobe,
  output logic              sdaBit,
  output logic              sdaPullLow
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic startDet, stopDet, sclRise, sclFall;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic isAddr;
  logic ackOk;

  // Two-flop (or deeper) synchronizers plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sdaBit   = sdaS;
  assign startDet = sclS && sclD && sdaD && !sdaS;
  assign stopDet  = sclS && sclD && !sdaD && sdaS;
  assign sclRise  = sclS && !sclD;
  assign sclFall  = !sclS && sclD;

  // Address byte: upper bits must match, direction bit must be write (0)
  assign ackOk = isAddr ? ((rxByte[BYTE_W-1:1] == DEV_ADDR) && !rxByte[0]) : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      isAddr <= 1'b1;
    end else if (!enable) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      isAddr <= 1'b1;
    end else if (startDet) begin
      state  <= ST_RECV;
      bitCnt <= '0;
      isAddr <= 1'b1;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_RECV: if (sclRise) begin
          if (bitCnt == LAST_BIT) begin
            state  <= ST_WAITACK;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_WAITACK: if (sclFall) state <= ackOk ? ST_ACK : ST_IGNORE;
        ST_ACK: if (sclFall) begin
          state  <= ST_RECV;
          isAddr <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (enable && !startDet && !stopDet) begin
      strobe.shiftEn     = (state == ST_RECV) && sclRise;
      strobe.loadPending = (state == ST_WAITACK) && sclFall && !isAddr;
    end
    strobe.stopSeen = enable && stopDet;
  end

  assign sdaPullLow = (state == ST_ACK);

  a_r11_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclS);

  a_r2_ack_ends_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow && sclFall && enable && !startDet && !stopDet) |=> !sdaPullLow);

  a_r3_ignore_until_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE && enable && !startDet) |=> (state == ST_IGNORE || state == ST_IDLE));

  a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sdaPullLow);
endmodule

// File: rtl/sp_setpoint_path.sv
module sp_setpoint_path
  import sp_target_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  ctlStrobe_t        strobe,
  input  logic              sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] dacCode,
  output logic              dacSel
);
  logic [BYTE_W-1:0] pending;
  logic pendValid;
  logic commit;

  assign commit = strobe.stopSeen && pendValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
    end else if (strobe.shiftEn) begin
      rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= '0;
      pendValid <= 1'b0;
    end else if (!enable) begin
      pendValid <= 1'b0;
    end else if (strobe.loadPending) begin
      pending   <= rxByte;
      pendValid <= 1'b1;
    end else if (strobe.stopSeen) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode <= '0;
      dacSel  <= 1'b0;
    end else begin
      if (commit) dacCode <= pending;
      if (!enable) dacSel <= 1'b0;
      else if (commit) dacSel <= 1'b1;
    end
  end

  a_r6_stop_commits: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopSeen && pendValid && enable) |=> (dacSel && dacCode == $past(pending)));

  a_r5_code_waits_for_stop: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stopSeen |=> $stable(dacCode));

  a_r8_no_data_no_select: assert property (@(posedge clk) disable iff (!rstN)
    (!pendValid && enable) |=> $stable(dacSel));

  a_r9_disable_releases: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !dacSel);
endmodule

// File: rtl/setpoint_i2c_target.sv
module setpoint_i2c_target
  import sp_target_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2C,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  output logic [BYTE_W-1:0] dacCode,
  output logic              dacSel
);
  ctlStrobe_t strobe;
  logic sdaBit;
  logic [BYTE_W-1:0] rxByte;

  sp_bus_ctl #(
    .DEV_ADDR    (DEV_ADDR),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .rxByte     (rxByte),
    .strobe     (strobe),
    .sdaBit     (sdaBit),
    .sdaPullLow (sdaPullLow)
  );

  sp_setpoint_path path (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .strobe  (strobe),
    .sdaBit  (sdaBit),
    .rxByte  (rxByte),
    .dacCode (dacCode),
    .dacSel  (dacSel)
  );
endmodule

// File: tb/setpoint_i2c_target_test.sv
module setpoint_i2c_target_test;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic mScl = 1'b1;
  logic mSdaLow = 1'b0;
  wire uutPull;
  wire sdaLine = !(mSdaLow || uutPull);
  wire [7:0] dacCode;
  wire dacSel;

  int checks = 0;
  int errors = 0;
  bit compareOn = 0;
  bit ackWindow = 0;
  bit done = 0;

  // Transaction-level model state
  logic [7:0] expCode = 8'h00;
  bit expSel = 0;
  logic [7:0] mPend = 8'h00;
  bit mPendValid = 0;

  always #10 clk = ~clk;

  setpoint_i2c_target #(.DEV_ADDR(DEV)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(mScl), .sdaIn(sdaLine),
    .sdaPullLow(uutPull), .dacCode(dacCode), .dacSel(dacSel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model (R5, R6, R9) and SDA discipline (R11)
  always @(negedge clk) begin
    if (compareOn && !done) begin
      check(dacCode == expCode, "R5 dacCode vs model", dacCode, expCode);
      check(dacSel == expSel, "R9 dacSel vs model", dacSel, expSel);
      if (uutPull && !ackWindow) check(0, "R11 SDA pulled outside ack slot", 1, 0);
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSdaLow = 0; waitClk(Q);
    mScl = 1;    waitClk(Q);
    mSdaLow = 1; waitClk(Q);
    mScl = 0;    waitClk(Q);
  endtask

  task automatic busStop();
    mSdaLow = 1; waitClk(Q);
    mScl = 1;    waitClk(Q);
    mSdaLow = 0;
    repeat (3) @(posedge clk);
    #1;
    if (mPendValid && enable) begin
      expCode = mPend;
      expSel = 1;
    end
    mPendValid = 0;
    waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSdaLow = !b[i]; waitClk(Q);
      mScl = 1;        waitClk(Q);
      if (i == 0) ackWindow = 1;
      mScl = 0;        waitClk(Q / 2);
    end
    mSdaLow = 0; waitClk(Q);
    mScl = 1;    waitClk(Q / 2);
    acked = !sdaLine;
    waitClk(Q / 2);
    mScl = 0;    waitClk(Q);
    ackWindow = 0;
  endtask

  // Address phase plus data bytes; expected acknowledges computed from R2/R3/R4/R9
  task automatic writeBody(input logic [6:0] addr, input bit rd, input logic [7:0] data[$], input string tag);
    bit acked;
    bit addrOk;
    addrOk = enable && (addr == DEV) && !rd;
    busStart();
    sendByte({addr, rd}, acked);
    check(acked == addrOk, {tag, " address ack"}, acked, addrOk);
    foreach (data[k]) begin
      sendByte(data[k], acked);
      check(acked == addrOk, {tag, " data ack"}, acked, addrOk);
      if (addrOk) begin
        mPend = data[k];
        mPendValid = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    waitClk(3);
    // R1: reset state
    check(dacCode == 8'h00, "R1 reset dacCode", dacCode, 0);
    check(dacSel == 0, "R1 reset dacSel", dacSel, 0);
    check(uutPull == 0, "R1 reset SDA released", uutPull, 0);
    rstN = 1;
    waitClk(5);
    compareOn = 1;

    // R8: address only, then STOP
    q = {};
    writeBody(DEV, 0, q, "R2 addr-only");
    busStop();
    check(dacSel == 0, "R8 no data keeps start-up mode", dacSel, 0);

    // R5 then R6: single byte
    q = {8'h5A};
    writeBody(DEV, 0, q, "R5 single");
    check(dacCode == 8'h00 && dacSel == 0, "R5 code waits for STOP", dacCode, 0);
    busStop();
    check(dacCode == 8'h5A, "R6 committed code", dacCode, 8'h5A);
    check(dacSel == 1, "R6 DAC selected", dacSel, 1);

    // R7: several bytes, last wins
    q = {8'h10, 8'h20, 8'h37};
    writeBody(DEV, 0, q, "R7 multi");
    busStop();
    check(dacCode == 8'h37, "R7 last byte committed", dacCode, 8'h37);

    // R3: wrong address
    q = {8'hC3};
    writeBody(DEV ^ 7'h01, 0, q, "R3 mismatch");
    busStop();
    check(dacCode == 8'h37, "R3 mismatch ignored", dacCode, 8'h37);

    // R4: read request
    q = {8'h99};
    writeBody(DEV, 1, q, "R4 read");
    busStop();
    check(dacCode == 8'h37, "R4 read ignored", dacCode, 8'h37);

    // R10: repeated START restarts decoding
    q = {8'h11};
    writeBody(DEV, 0, q, "R10 first");
    q = {8'h22};
    writeBody(DEV, 0, q, "R10 restart");
    busStop();
    check(dacCode == 8'h22, "R10 restart commit", dacCode, 8'h22);
    q = {8'h44};
    writeBody(DEV, 0, q, "R10 keep");
    q = {8'h55};
    writeBody(7'h10, 0, q, "R10 bad restart");
    busStop();
    check(dacCode == 8'h44, "R10 pending kept over restart", dacCode, 8'h44);

    // R9: disable, transfer while disabled, re-enable
    enable = 0;
    @(posedge clk); #1;
    expSel = 0;
    mPendValid = 0;
    waitClk(2);
    check(dacSel == 0, "R9 disable clears select", dacSel, 0);
    q = {8'h66};
    writeBody(DEV, 0, q, "R9 disabled");
    busStop();
    check(dacCode == 8'h44, "R9 disabled write ignored", dacCode, 8'h44);
    waitClk(1);
    enable = 1;
    waitClk(5);
    check(dacSel == 0, "R9 re-enable is start-up mode", dacSel, 0);
    q = {8'h7E};
    writeBody(DEV, 0, q, "R9 after enable");
    busStop();
    check(dacCode == 8'h7E && dacSel == 1, "R9 DAC regains control", dacCode, 8'h7E);

    waitClk(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule